// File: doc/BRIEF.md
# Readback CRC-8 Guard with Data-Ready Timing

This block watches the serial readout path of a converter front end. Each bit the serial shifter drives onto the data-out line goes into a running 8-bit cyclic redundancy check. The result can be read back as one more byte. The host reads that byte after the data bytes and compares it with its own checksum. Bits of the checksum byte itself are flagged by the shifter and kept out of the sum, so the host can read the checksum any number of times and get the same value.

The block also drives the active-low data-ready line. A new-data pulse pulls the line low. The periodic output-rate tick releases it. The line's release also clears the checksum, because a new conversion set begins there. Two configuration bits change this behaviour:
- The first bit releases data-ready as soon as the last bit of the checksum byte has been shifted. The periodic tick still releases it at the latest.
- The second bit stops the release from clearing the checksum, so a readout can run past the period boundary.

Raising chip select always clears the checksum.

Top module: `rdcrc_guard`

## Requirements
- R1: After reset the checksum register is zero, so `crc_out` reads 0xFF, and `rdy_n` is high.
- R2: On each `shift_stb` cycle with `crc_en` high, `cs_n` low and `crc_sel` low, the register takes `shift_bit` MSB-first: next = {reg[6:0],0} XOR (reg[7] XOR bit ? 0x31 : 0x00). The 0x31 value encodes the polynomial x^8+x^5+x^4+1.
- R3: `crc_out` is always the bitwise complement of the register, with no extra latency.
- R4: A strobe with `crc_sel` high marks a bit of the checksum byte itself and leaves the register unchanged.
- R5: While `cs_n` is high, the register is cleared on each clock and the checksum-byte bit count returns to zero. Strobes are ignored.
- R6: While `crc_en` is low, data bits do not change the register.
- R7: A `new_data` pulse drives `rdy_n` low on the next cycle. It wins over any release in the same cycle.
- R8: A `period_tick` drives `rdy_n` high on the next cycle, unless `new_data` is also high.
- R9: In a cycle where `rdy_n` goes from low to high, the register is cleared unless `keep_on_rdy` is high. When `keep_on_rdy` is high, the register keeps its value.
- R10: With `rdy_after_read` high, the eighth `crc_sel` strobe since `cs_n` fell (and each eighth after it) releases `rdy_n` on the next cycle. With `rdy_after_read` low, that strobe has no effect on `rdy_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| crc_en | input | 1 | Checksum accumulation enable |
| rdy_after_read | input | 1 | Release data-ready after the checksum byte has been read |
| keep_on_rdy | input | 1 | Do not clear the checksum on data-ready release |
| cs_n | input | 1 | Chip select, active low |
| shift_stb | input | 1 | One-cycle strobe per bit shifted out |
| shift_bit | input | 1 | Bit value driven out on this strobe |
| crc_sel | input | 1 | The strobed bit belongs to the checksum byte |
| new_data | input | 1 | New conversion result available |
| period_tick | input | 1 | Output-rate period boundary |
| crc_out | output | 8 | Complemented checksum for readback |
| rdy_n | output | 1 | Data-ready, active low |

## Verification
Directed byte streams with known contents show that the MSB-first feed and the 0x31 feedback are correct. Interleaving checksum-byte strobes between data bits shows that checksum bits are kept out of the sum. A long constrained-random phase mixes strobes, chip-select toggles, ticks, new-data pulses and all combinations of the three option bits. It is compared cycle by cycle with a bench model. Collisions between tick and new-data, and between release and clearing, show whether the priorities and the clear-suppress option hold in every combination. Focused sequences run one eight-bit checksum read with the early-release option on and then off. They show that release happens only on the final bit, and only when the option is set.

// File: rtl/rdcrc_pkg.sv
package rdcrc_pkg;

    localparam int CRC_W    = 8;
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h31;
    localparam int BITCNT_W = $clog2(CRC_W);

    typedef struct packed {
        logic en;
        logic hold_rdy;
        logic keep;
    } crc_cfg_t;

    typedef struct packed {
        logic stb;
        logic dat;
        logic sel;
    } sdo_bit_t;

    typedef enum logic {
        RDY_HIGH = 1'b1,
        RDY_LOW  = 1'b0
    } rdy_lvl_e;

    function automatic logic [CRC_W-1:0] crc_step(
        input logic [CRC_W-1:0] cur,
        input logic             b
    );
        logic fb;
        fb = cur[CRC_W-1] ^ b;
        return {cur[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/rdcrc_readtrack.sv
module rdcrc_readtrack
    import rdcrc_pkg::*;
#(
    parameter int W  = CRC_W,
    localparam int CW = (W > 1) ? $clog2(W) : 1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_n,
    input  sdo_bit_t sbit,
    output logic     read_done
);
    logic [CW-1:0] cnt_q;
    logic          last;

    assign last      = (cnt_q == CW'(W-1));
    assign read_done = !cs_n && sbit.stb && sbit.sel && last;

    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            cnt_q <= '0;
        end else if (sbit.stb && sbit.sel) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rdcrc_rdyctl.sv
module rdcrc_rdyctl
    import rdcrc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  crc_cfg_t cfg,
    input  logic     new_data,
    input  logic     period_tick,
    input  logic     read_done,
    output logic     rdy_n,
    output logic     rdy_rise
);
    rdy_lvl_e lvl_q, lvl_d;
    logic     release_req;

    assign release_req = period_tick || (cfg.hold_rdy && read_done);

    always_comb begin
        lvl_d = lvl_q;
        if (new_data)         lvl_d = RDY_LOW;
        else if (release_req) lvl_d = RDY_HIGH;
    end

    assign rdy_rise = (lvl_q == RDY_LOW) && (lvl_d == RDY_HIGH);
    assign rdy_n    = (lvl_q == RDY_HIGH);

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= RDY_HIGH;
        else     lvl_q <= lvl_d;
    end
endmodule

// File: rtl/rdcrc_accum.sv
module rdcrc_accum
    import rdcrc_pkg::*;
#(
    parameter int W = CRC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  crc_cfg_t     cfg,
    input  logic         cs_n,
    input  sdo_bit_t     sbit,
    input  logic         rdy_rise,
    output logic [W-1:0] crc_q
);
    logic clr;
    logic take;

    assign clr  = cs_n || (rdy_rise && !cfg.keep);
    assign take = cfg.en && sbit.stb && !sbit.sel;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc_q <= '0;
        end else if (take) begin
            crc_q <= crc_step(crc_q, sbit.dat);
        end
    end
endmodule

// File: rtl/rdcrc_guard.sv
module rdcrc_guard
    import rdcrc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             crc_en,
    input  logic             rdy_after_read,
    input  logic             keep_on_rdy,
    input  logic             cs_n,
    input  logic             shift_stb,
    input  logic             shift_bit,
    input  logic             crc_sel,
    input  logic             new_data,
    input  logic             period_tick,
    output logic [CRC_W-1:0] crc_out,
    output logic             rdy_n
);
    crc_cfg_t         cfg;
    sdo_bit_t         sbit;
    logic             read_done;
    logic             rdy_rise;
    logic [CRC_W-1:0] crc_q;

    assign cfg  = '{en: crc_en, hold_rdy: rdy_after_read, keep: keep_on_rdy};
    assign sbit = '{stb: shift_stb, dat: shift_bit, sel: crc_sel};

    rdcrc_readtrack #(.W(CRC_W)) u_track (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sbit(sbit), .read_done(read_done)
    );

    rdcrc_rdyctl u_rdy (
        .clk(clk), .rst(rst), .cfg(cfg), .new_data(new_data),
        .period_tick(period_tick), .read_done(read_done),
        .rdy_n(rdy_n), .rdy_rise(rdy_rise)
    );

    rdcrc_accum #(.W(CRC_W)) u_acc (
        .clk(clk), .rst(rst), .cfg(cfg), .cs_n(cs_n), .sbit(sbit),
        .rdy_rise(rdy_rise), .crc_q(crc_q)
    );

    assign crc_out = ~crc_q;
endmodule

// File: rtl/rdcrc_guard_chk.sv
module rdcrc_guard_chk
    import rdcrc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             crc_en,
    input logic             rdy_after_read,
    input logic             keep_on_rdy,
    input logic             cs_n,
    input logic             shift_stb,
    input logic             crc_sel,
    input logic             new_data,
    input logic             period_tick,
    input logic [CRC_W-1:0] crc_out,
    input logic             rdy_n
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (rdy_n && crc_out == '1));

    a_r5_cs_clears: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> crc_out == '1);

    a_r7_new_data_low: assert property (@(posedge clk) disable iff (rst)
        new_data |=> !rdy_n);

    a_r8_tick_high: assert property (@(posedge clk) disable iff (rst)
        (period_tick && !new_data) |=> rdy_n);

    a_r4_self_bits_skip: assert property (@(posedge clk) disable iff (rst)
        (shift_stb && crc_sel && !cs_n && !period_tick && !rdy_after_read)
        |=> $stable(crc_out));

    a_r6_disabled_hold: assert property (@(posedge clk) disable iff (rst)
        (!crc_en && !cs_n && !period_tick && !rdy_after_read)
        |=> $stable(crc_out));

    a_r9_keep_hold: assert property (@(posedge clk) disable iff (rst)
        (keep_on_rdy && !crc_en && !cs_n) |=> $stable(crc_out));

    a_r10_no_early_release: assert property (@(posedge clk) disable iff (rst)
        (!rdy_n && !period_tick && !rdy_after_read) |=> !rdy_n);
endmodule

bind rdcrc_guard rdcrc_guard_chk u_chk (
    .clk(clk), .rst(rst), .crc_en(crc_en), .rdy_after_read(rdy_after_read),
    .keep_on_rdy(keep_on_rdy), .cs_n(cs_n), .shift_stb(shift_stb),
    .crc_sel(crc_sel), .new_data(new_data), .period_tick(period_tick),
    .crc_out(crc_out), .rdy_n(rdy_n)
);

// File: tb/rdcrc_guard_test.sv
module rdcrc_guard_test;
    logic       clk = 1'b0;
    logic       rst, crc_en, rdy_after_read, keep_on_rdy, cs_n;
    logic       shift_stb, shift_bit, crc_sel, new_data, period_tick;
    logic [7:0] crc_out;
    logic       rdy_n;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [7:0] m_crc;
    logic       m_rdy;
    int         m_cnt;

    always #5 clk = ~clk;

    rdcrc_guard uut (.*);

    function automatic logic [7:0] ref_step(input logic [7:0] c, input logic b);
        logic [7:0] s;
        s = c << 1;
        if (c[7] != b) s = s ^ 8'h31;
        return s;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Model next state from current inputs (R2, R4-R10)
    task automatic model_edge();
        logic done_rd, rise, nrdy;
        done_rd = !cs_n && shift_stb && crc_sel && (m_cnt == 7);
        nrdy = m_rdy;
        if (new_data) nrdy = 1'b0;
        else if (period_tick || (rdy_after_read && done_rd)) nrdy = 1'b1;
        rise = !m_rdy && nrdy;
        if (cs_n || (rise && !keep_on_rdy)) m_crc = 8'h00;
        else if (crc_en && shift_stb && !crc_sel) m_crc = ref_step(m_crc, shift_bit);
        if (cs_n) m_cnt = 0;
        else if (shift_stb && crc_sel) m_cnt = (m_cnt == 7) ? 0 : m_cnt + 1;
        m_rdy = nrdy;
    endtask

    task automatic cycle(input string req);
        model_edge();
        @(posedge clk);
        @(negedge clk);
        check({req, " crc"}, {24'd0, crc_out}, {24'd0, ~m_crc});
        check({req, " rdy"}, {31'd0, rdy_n}, {31'd0, m_rdy});
    endtask

    task automatic idle();
        shift_stb = 0; shift_bit = 0; crc_sel = 0; new_data = 0; period_tick = 0;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic sel, input string req);
        for (int i = 7; i >= 0; i--) begin
            idle(); shift_stb = 1; shift_bit = b[i]; crc_sel = sel;
            cycle(req);
        end
        idle();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] saved;
        void'($urandom(32'h1234_5678));
        rst = 1; crc_en = 0; rdy_after_read = 0; keep_on_rdy = 0; cs_n = 1;
        idle();
        m_crc = 0; m_rdy = 1; m_cnt = 0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        // R1 reset state
        check("R1 crc", {24'd0, crc_out}, 32'hFF);
        check("R1 rdy", {31'd0, rdy_n}, 32'd1);
        rst = 0;

        // R2/R3 directed bytes
        crc_en = 1; cs_n = 0; cycle("R5");
        new_data = 1; cycle("R7"); idle();
        send_byte(8'hA5, 0, "R2");
        send_byte(8'h3C, 0, "R2");
        saved = crc_out;
        // R4 checksum bits excluded, repeat read gives same value
        send_byte(crc_out, 1, "R4");
        check("R4 repeat", {24'd0, crc_out}, {24'd0, saved});
        send_byte(crc_out, 1, "R4");
        check("R4 repeat2", {24'd0, crc_out}, {24'd0, saved});
        // R6 disabled
        crc_en = 0; send_byte(8'hFF, 0, "R6");
        check("R6 held", {24'd0, crc_out}, {24'd0, saved});
        crc_en = 1;
        // R10 without option: no release after read
        send_byte(8'h00, 1, "R10");
        check("R10 no release", {31'd0, rdy_n}, 32'd0);
        // R10 with option: release on 8th bit, R9 clears
        rdy_after_read = 1;
        send_byte(8'h00, 1, "R10");
        check("R10 released", {31'd0, rdy_n}, 32'd1);
        check("R9 cleared", {24'd0, crc_out}, 32'hFF);
        rdy_after_read = 0;
        // R9 keep option across tick
        new_data = 1; cycle("R7"); idle();
        send_byte(8'h5A, 0, "R2");
        saved = crc_out;
        keep_on_rdy = 1; period_tick = 1; cycle("R8"); idle();
        check("R9 kept", {24'd0, crc_out}, {24'd0, saved});
        check("R8 released", {31'd0, rdy_n}, 32'd1);
        keep_on_rdy = 0;
        // R7/R8 collision
        new_data = 1; period_tick = 1; cycle("R7"); idle();
        check("R7 wins", {31'd0, rdy_n}, 32'd0);
        // R5 chip select clears
        send_byte(8'h77, 0, "R2");
        cs_n = 1; cycle("R5"); cs_n = 0;
        check("R5 cleared", {24'd0, crc_out}, 32'hFF);

        // constrained random
        for (int n = 0; n < 20000; n++) begin
            if (($urandom % 64) == 0) crc_en = $urandom % 4 != 0;
            if (($urandom % 64) == 0) rdy_after_read = $urandom % 2;
            if (($urandom % 64) == 0) keep_on_rdy = $urandom % 2;
            if (($urandom % 40) == 0) cs_n = ~cs_n;
            shift_stb   = ($urandom % 3) != 0;
            shift_bit   = $urandom % 2;
            crc_sel     = ($urandom % 4) == 0;
            new_data    = ($urandom % 30) == 0;
            period_tick = ($urandom % 30) == 0;
            cycle("R2/R9 random");
        end
        idle();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule